// File: doc/BRIEF.md
# Multi-Cycle Fetch and Load-Post-Increment Sequencer

This block is the finite-state controller for a multi-cycle datapath. The datapath holds a program counter, a memory address register, a memory data register, an instruction register, a base-operand latch and an ALU result latch. It has one memory port and one register-file write port. On each clock the sequencer raises the enables for one step of work. It fetches an instruction in three steps and then decodes it. A load-with-post-increment instruction runs a dedicated sequence. Every other opcode goes to a single generic execute step.

The program counter advances by four while the fetch read is in flight. The post-incremented base address is computed by the ALU while the load read is in flight. The design never places two memory accesses or two register writes in the same cycle, so the load ends with two separate write-back steps. The first writes the loaded data and the second writes the updated base. The sequencer then returns to the start of fetch. Memory reads are completed by a data-valid handshake. While that input is low, the sequencer stays in the current read step.

Top module: `fetch_ld_seq`

## Requirements
- R1: An asynchronous active-low reset puts the sequencer in the first fetch step at once. There it drives `mar_ld`=1 and every other control output 0, and it stays there while reset is held.
- R2: The first fetch step drives only `mar_ld`. It moves to the second fetch step on the next clock whatever `mem_valid` is.
- R3: The second fetch step drives `mem_rd`=1 with `mem_addr_sel`=0 (address from the memory address register). While `mem_valid` is 0, `mdr_ld` and `pc_inc` are 0 and the step repeats. In the cycle `mem_valid` is 1, both `mdr_ld` and `pc_inc` are 1, and the next step is the third fetch step. So the program counter advances exactly once per fetch.
- R4: The third fetch step drives only `ir_ld` and is always followed by the decode step.
- R5: The decode step drives only `a_ld`, which latches the base register. If `ir_opcode` equals the parameter `LOAD_OPC` (default 6'h31), the next step is the load-execute step. Otherwise the next step is the generic execute step.
- R6: The generic execute step drives only `exec_en` for one cycle and then returns to the first fetch step.
- R7: The load-execute step drives `mem_rd`=1, `mem_addr_sel`=1 (address from the base latch) and `aluo_ld`=1. `mdr_ld` equals `mem_valid`. The step repeats while `mem_valid` is 0.
- R8: After the load read completes, one cycle drives `rf_we`=1 with `rf_wsel`=0 (destination register takes the loaded data). The next cycle drives `rf_we`=1 with `rf_wsel`=1 (base register takes base+4). Then the first fetch step follows.
- R9: `mem_rd` and `rf_we` are never 1 in the same cycle.
- R10: `ir_opcode` is ignored in every step except decode, and `mem_valid` is ignored outside the two read steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mem_valid | input | 1 | Memory read data valid |
| ir_opcode | input | OPC_W (6) | Opcode field of the instruction register |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr_sel | output | 1 | Memory address source: 0 address register, 1 base latch |
| mar_ld | output | 1 | Load memory address register from program counter |
| mdr_ld | output | 1 | Load memory data register from memory |
| pc_inc | output | 1 | Program counter takes PC+4 |
| ir_ld | output | 1 | Load instruction register from memory data register |
| a_ld | output | 1 | Latch base register value from register file |
| aluo_ld | output | 1 | Latch ALU result (base+4) |
| rf_we | output | 1 | Register-file write enable |
| rf_wsel | output | 1 | Write select: 0 data to destination, 1 ALU result to base |
| exec_en | output | 1 | Generic execute step enable |

## Verification
The assertions assume that `mem_valid` is only meaningful while `mem_rd` is high, that `ir_opcode` already reflects the new instruction register in the decode cycle, and that reset deassertion is synchronous to the clock. The stimulus changes `mem_valid` and `ir_opcode` only on falling edges and releases reset on a falling edge. It holds `mem_valid` low for zero to three cycles inside each read step. It deliberately drives `mem_valid` high and presents the load opcode in steps where both must be ignored, so any leakage of those inputs shows up in the expected control vectors.

// File: rtl/fetch_ld_seq_pkg.sv
`timescale 1ns/1ps
package fetch_ld_seq_pkg;
  typedef enum logic [2:0] {
    ST_FA   = 3'd0,  // PC to MAR
    ST_FB   = 3'd1,  // memory read into MDR, PC+4
    ST_FC   = 3'd2,  // MDR to IR
    ST_DEC  = 3'd3,  // decode, latch base register
    ST_EXE  = 3'd4,  // generic execute
    ST_LX   = 3'd5,  // load read at base, ALU base+4
    ST_WBD  = 3'd6,  // write loaded data
    ST_WBB  = 3'd7   // write incremented base
  } seq_state_t;

  typedef struct packed {
    logic mem_rd;
    logic mem_addr_sel;
    logic mar_ld;
    logic mdr_ld;
    logic pc_inc;
    logic ir_ld;
    logic a_ld;
    logic aluo_ld;
    logic rf_we;
    logic rf_wsel;
    logic exec_en;
  } seq_ctl_t;
endpackage

// File: rtl/fetch_ld_seq_next.sv
`timescale 1ns/1ps
module fetch_ld_seq_next
  import fetch_ld_seq_pkg::*;
#(
  parameter int                OPC_W    = 6,
  parameter logic [OPC_W-1:0]  LOAD_OPC = 6'h31
) (
  input  seq_state_t        cur_st,
  input  logic              mem_valid,
  input  logic [OPC_W-1:0]  opcode,
  output seq_state_t        nxt_st
);
  logic is_load;
  assign is_load = (opcode == LOAD_OPC);

  always_comb begin
    nxt_st = cur_st;
    unique case (cur_st)
      ST_FA:  nxt_st = ST_FB;
      ST_FB:  nxt_st = mem_valid ? ST_FC : ST_FB;
      ST_FC:  nxt_st = ST_DEC;
      ST_DEC: nxt_st = is_load ? ST_LX : ST_EXE;
      ST_EXE: nxt_st = ST_FA;
      ST_LX:  nxt_st = mem_valid ? ST_WBD : ST_LX;
      ST_WBD: nxt_st = ST_WBB;
      ST_WBB: nxt_st = ST_FA;
      default: nxt_st = ST_FA;
    endcase
  end
endmodule

// File: rtl/fetch_ld_seq_outdec.sv
`timescale 1ns/1ps
module fetch_ld_seq_outdec
  import fetch_ld_seq_pkg::*;
(
  input  seq_state_t cur_st,
  input  logic       mem_valid,
  output seq_ctl_t   ctl
);
  always_comb begin
    ctl = '0;
    unique case (cur_st)
      ST_FA:  ctl.mar_ld = 1'b1;
      ST_FB: begin
        ctl.mem_rd = 1'b1;
        ctl.mdr_ld = mem_valid;
        ctl.pc_inc = mem_valid;
      end
      ST_FC:  ctl.ir_ld = 1'b1;
      ST_DEC: ctl.a_ld = 1'b1;
      ST_EXE: ctl.exec_en = 1'b1;
      ST_LX: begin
        ctl.mem_rd       = 1'b1;
        ctl.mem_addr_sel = 1'b1;
        ctl.aluo_ld      = 1'b1;
        ctl.mdr_ld       = mem_valid;
      end
      ST_WBD: ctl.rf_we = 1'b1;
      ST_WBB: begin
        ctl.rf_we   = 1'b1;
        ctl.rf_wsel = 1'b1;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/fetch_ld_seq.sv
`timescale 1ns/1ps
module fetch_ld_seq
  import fetch_ld_seq_pkg::*;
#(
  parameter int                OPC_W    = 6,
  parameter logic [OPC_W-1:0]  LOAD_OPC = 6'h31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_valid,
  input  logic [OPC_W-1:0]  ir_opcode,
  output logic              mem_rd,
  output logic              mem_addr_sel,
  output logic              mar_ld,
  output logic              mdr_ld,
  output logic              pc_inc,
  output logic              ir_ld,
  output logic              a_ld,
  output logic              aluo_ld,
  output logic              rf_we,
  output logic              rf_wsel,
  output logic              exec_en
);
  seq_state_t st_q, st_d;
  seq_ctl_t   ctl;

  fetch_ld_seq_next #(.OPC_W(OPC_W), .LOAD_OPC(LOAD_OPC)) u_next (
    .cur_st    (st_q),
    .mem_valid (mem_valid),
    .opcode    (ir_opcode),
    .nxt_st    (st_d)
  );

  fetch_ld_seq_outdec u_dec (
    .cur_st    (st_q),
    .mem_valid (mem_valid),
    .ctl       (ctl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_FA;
    else        st_q <= st_d;
  end

  assign mem_rd       = ctl.mem_rd;
  assign mem_addr_sel = ctl.mem_addr_sel;
  assign mar_ld       = ctl.mar_ld;
  assign mdr_ld       = ctl.mdr_ld;
  assign pc_inc       = ctl.pc_inc;
  assign ir_ld        = ctl.ir_ld;
  assign a_ld         = ctl.a_ld;
  assign aluo_ld      = ctl.aluo_ld;
  assign rf_we        = ctl.rf_we;
  assign rf_wsel      = ctl.rf_wsel;
  assign exec_en      = ctl.exec_en;

  // R3: a pending fetch read holds its step
  a_r3_fetch_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FB && !mem_valid) |=> (st_q == ST_FB));
  // R3: the PC advances at most once per fetch
  a_r3_pc_single_inc: assert property (@(posedge clk) disable iff (!rst_n)
    pc_inc |=> !pc_inc);
  // R4: IR loads only right after the MDR captured data
  a_r4_ir_after_mdr: assert property (@(posedge clk) disable iff (!rst_n)
    ir_ld |-> $past(mdr_ld));
  // R7: a pending load read holds its step
  a_r7_load_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr_sel && !mem_valid) |=> (mem_rd && mem_addr_sel));
  // R8: data write is followed by base write, then fetch
  a_r8_wb_order: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && !rf_wsel) |=> (rf_we && rf_wsel));
  a_r8_wb_return: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && rf_wsel) |=> mar_ld);
  // R9: the single memory port and single write port never collide
  a_r9_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && rf_we));
endmodule

// File: tb/fetch_ld_seq_tb_top.sv
`timescale 1ns/1ps
module fetch_ld_seq_tb_top;
  localparam logic [5:0] OP_LD  = 6'h31;
  localparam logic [5:0] OP_ADD = 6'h00;
  localparam logic [5:0] OP_OTH = 6'h12;

  localparam logic [10:0] B_MAR = 11'h400, B_MRD = 11'h200, B_ASEL = 11'h100,
                          B_MDR = 11'h080, B_PCI = 11'h040, B_IR   = 11'h020,
                          B_A   = 11'h010, B_ALU = 11'h008, B_WE   = 11'h004,
                          B_WS  = 11'h002, B_EX  = 11'h001;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, mem_valid;
  logic [5:0] ir_opcode;
  logic mem_rd, mem_addr_sel, mar_ld, mdr_ld, pc_inc, ir_ld, a_ld, aluo_ld,
        rf_we, rf_wsel, exec_en;

  fetch_ld_seq dut_i (
    .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .ir_opcode(ir_opcode),
    .mem_rd(mem_rd), .mem_addr_sel(mem_addr_sel), .mar_ld(mar_ld),
    .mdr_ld(mdr_ld), .pc_inc(pc_inc), .ir_ld(ir_ld), .a_ld(a_ld),
    .aluo_ld(aluo_ld), .rf_we(rf_we), .rf_wsel(rf_wsel), .exec_en(exec_en)
  );

  logic [10:0] exp_q[$];
  string       tag_q[$];
  int          checks = 0;
  int          errors = 0;
  bit          done   = 1'b0;

  function automatic logic [10:0] observed();
    return {mar_ld, mem_rd, mem_addr_sel, mdr_ld, pc_inc, ir_ld, a_ld,
            aluo_ld, rf_we, rf_wsel, exec_en};
  endfunction

  task automatic check_now(input logic [10:0] e, input string t);
    checks++;
    if (observed() !== e) begin
      errors++;
      $display("FAIL %s: got %b expected %b", t, observed(), e);
    end
  endtask

  // driver: one expected control vector per cycle
  task automatic step(input logic v, input logic [5:0] op,
                      input logic [10:0] e, input string t);
    @(negedge clk);
    mem_valid = v;
    ir_opcode = op;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic fetch_a(input logic v, input logic [5:0] op);
    step(v, op, B_MAR, "R2");
  endtask

  task automatic fetch_tail(input int nwait, input logic [5:0] op);
    for (int i = 0; i < nwait; i++) step(1'b0, op, B_MRD, "R3");
    step(1'b1, op, B_MRD | B_MDR | B_PCI, "R3");
    step(1'b1, op, B_IR, "R4");  // mem_valid high here must be ignored (R10)
  endtask

  task automatic decode(input logic [5:0] op);
    step(1'b0, op, B_A, "R5");
  endtask

  task automatic gen_exec();
    step(1'b1, OP_LD, B_EX, "R6");  // opcode and valid ignored (R10)
  endtask

  task automatic load_seq(input int nwait);
    for (int i = 0; i < nwait; i++)
      step(1'b0, OP_ADD, B_MRD | B_ASEL | B_ALU, "R7");
    step(1'b1, OP_ADD, B_MRD | B_ASEL | B_ALU | B_MDR, "R7");
    step(1'b0, OP_LD, B_WE, "R8");
    step(1'b1, OP_LD, B_WE | B_WS, "R8");
  endtask

  // monitor: pop and compare away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (exp_q.size() > 0) begin
        logic [10:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check_now(e, t);
        checks++;
        if (mem_rd && rf_we) begin
          errors++;
          $display("FAIL R9: mem_rd=%b rf_we=%b expected not both 1", mem_rd, rf_we);
        end
      end
    end
  end

  initial begin
    rst_n = 1'b0; mem_valid = 1'b1; ir_opcode = OP_LD;
    repeat (2) @(negedge clk);
    #3 check_now(B_MAR, "R1");
    @(negedge clk);
    rst_n = 1'b1; mem_valid = 1'b1; ir_opcode = OP_LD;
    exp_q.push_back(B_MAR); tag_q.push_back("R1");

    // load opcode during fetch must not matter (R10)
    fetch_tail(0, OP_LD);  decode(OP_ADD); gen_exec();
    fetch_a(1'b1, OP_LD);  fetch_tail(2, OP_ADD); decode(OP_LD); load_seq(0);
    fetch_a(1'b0, OP_ADD); fetch_tail(1, OP_LD);  decode(OP_LD); load_seq(3);
    fetch_a(1'b0, OP_LD);  fetch_tail(0, OP_LD);  decode(OP_OTH); gen_exec();
    fetch_a(1'b0, OP_ADD); fetch_tail(0, OP_ADD); decode(OP_LD);

    // reset in the middle of a load returns to the first fetch step
    @(negedge clk);
    rst_n = 1'b0;
    #2 check_now(B_MAR, "R1");
    @(negedge clk);
    #2 check_now(B_MAR, "R1");
    @(negedge clk);
    rst_n = 1'b1; mem_valid = 1'b0; ir_opcode = OP_ADD;
    exp_q.push_back(B_MAR); tag_q.push_back("R1");

    fetch_tail(0, OP_ADD); decode(OP_LD); load_seq(1);
    fetch_a(1'b0, OP_ADD);  // return after base write-back (R8)
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule